// File: doc/BRIEF.md
# Instruction Set State Controller

This block keeps track of which of four instruction-set execution states a processor front end is running in. The state lives in two status flags, J and T. The decoder sends one-cycle pulses for each class of state-changing instruction: branch-exchange, branch-exchange-to-bytecode, enter-extended and leave-extended. Each pulse comes with the branch target address. The controller accepts a pulse only if it names an allowed transition from the current state, and it applies the change one cycle later.

Alongside the transitions, the controller checks every fetch address against the alignment rule of the current state. It also checks branch targets against the alignment rule of the state they lead to. It raises one-cycle pulses for illegal requests and for alignment faults.

The flags appear at fixed bit positions inside a status-register image, and a write port loads them directly. Accepted branches produce a redirect address for the fetch unit. All other processor state is left to other blocks.

Top module: `isa_state_ctrl`

## Requirements
- R1: {J,T} encodes the state as 00 = 32-bit fixed-width, 01 = compact, 10 = bytecode, 11 = extended compact. After reset the flags read 00.
- R2: With fetch_valid high, a fetch address whose two low bits are non-zero in state 00, or whose bit 0 is set in state 01 or 11, raises align_fault for one cycle. Any fetch address is accepted in state 10.
- R3: A req_bx pulse in state 00 or 01 moves to state 01 if br_target bit 0 is 1, or to state 00 if it is 0. It also raises redirect_valid with redirect_addr equal to br_target with bit 0 cleared.
- R4: A req_enter pulse moves state 01 to 11, and a req_leave pulse moves state 11 to 01. Neither produces a redirect.
- R5: A req_bxj pulse in state 00 or 01 moves to state 10 and redirects to br_target unchanged.
- R6: A request that is not allowed from the current state, or more than one request pulse in the same cycle, raises illegal_transition for one cycle. The flags stay unchanged and there is no redirect.
- R7: A legal request does not change the flags and produces no redirect when either of these holds in the same cycle: a fetch misalignment as in R2, or a branch-exchange target to state 00 whose bit 1 is set after bit 0 is cleared. In that case align_fault is raised.
- R8: When sr_wr_en is high, the flags load sr_wr_jt (bit 1 = J, bit 0 = T). Any request in the same cycle is ignored: no illegal_transition and no redirect.
- R9: All outputs are registered. A change caused in one cycle is visible in the next cycle, and fault and redirect pulses last exactly one cycle.
- R10: sr_image carries J at bit J_POS and T at bit T_POS. Every other bit reads 0, so a state change touches nothing but J and T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_bx | input | 1 | Branch-exchange pulse |
| req_bxj | input | 1 | Branch-exchange-to-bytecode pulse |
| req_enter | input | 1 | Enter-extended pulse |
| req_leave | input | 1 | Leave-extended pulse |
| br_target | input | ADDR_W | Branch target address |
| fetch_valid | input | 1 | Fetch address below is valid this cycle |
| fetch_addr_lsb | input | 2 | Two low bits of the fetch address |
| sr_wr_en | input | 1 | Status-register write strobe |
| sr_wr_jt | input | 2 | Written flags: bit 1 = J, bit 0 = T |
| j_flag | output | 1 | J flag |
| t_flag | output | 1 | T flag |
| sr_image | output | SR_W | Status-register image holding J and T |
| illegal_transition | output | 1 | One-cycle pulse for a disallowed request |
| align_fault | output | 1 | One-cycle pulse for an alignment violation |
| redirect_valid | output | 1 | One-cycle pulse for an accepted branch |
| redirect_addr | output | ADDR_W | Branch address for the fetch unit |

## Verification
The bound checker watches several properties on every cycle. Any change of the flags without a write must follow one of the six allowed edges. Illegal or misaligned requests must leave the flags alone. A write must win over any same-cycle request. Redirects must carry bit 0 cleared outside the bytecode state, and entry into the bytecode state must redirect to the raw target. Some behaviour only the bench's scenarios can show: that bit 0 of a branch target picks the destination state, the per-state fetch alignment table, that several simultaneous pulses are refused, and that the image keeps every other bit at zero.

// File: rtl/isa_state_pkg.sv
`timescale 1ns/1ps
package isa_state_pkg;

  // Encoding is {J,T}; neighbouring logic decodes these values.
  typedef enum logic [1:0] {
    ISA_FIXED32    = 2'b00,
    ISA_COMPACT    = 2'b01,
    ISA_BYTECODE   = 2'b10,
    ISA_EXTCOMPACT = 2'b11
  } isa_state_e;

  typedef struct packed {
    logic bx;
    logic bxj;
    logic enter;
    logic leave;
  } isa_req_t;

  typedef enum logic [2:0] {
    REQ_NONE,
    REQ_BX,
    REQ_BXJ,
    REQ_ENTER,
    REQ_LEAVE,
    REQ_MULTI
  } req_kind_e;

endpackage

// File: rtl/isa_rst_sync.sv
`timescale 1ns/1ps
module isa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  generate
    if (STAGES <= 1) begin : g_single
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= 1'b0;
        else          sync_q <= 1'b1;
      end
      assign rst_n_o = sync_q;
    end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= '0;
        else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
      assign rst_n_o = sync_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/isa_req_decode.sv
`timescale 1ns/1ps
module isa_req_decode
  import isa_state_pkg::*;
(
  input  isa_req_t  req_i,
  output req_kind_e kind_o
);

  logic [2:0] pulse_cnt;

  always_comb begin
    pulse_cnt = 3'($countones(req_i));
    kind_o    = REQ_NONE;
    if (pulse_cnt > 3'd1) begin
      kind_o = REQ_MULTI;
    end else if (req_i.bx) begin
      kind_o = REQ_BX;
    end else if (req_i.bxj) begin
      kind_o = REQ_BXJ;
    end else if (req_i.enter) begin
      kind_o = REQ_ENTER;
    end else if (req_i.leave) begin
      kind_o = REQ_LEAVE;
    end
  end

endmodule

// File: rtl/isa_transition_rules.sv
`timescale 1ns/1ps
module isa_transition_rules
  import isa_state_pkg::*;
(
  input  isa_state_e cur_i,
  input  req_kind_e  kind_i,
  input  logic       tgt_lsb_i,
  output logic       legal_o,
  output isa_state_e dest_o
);

  logic from_branchable;

  always_comb begin
    from_branchable = (cur_i == ISA_FIXED32) || (cur_i == ISA_COMPACT);
    legal_o = 1'b0;
    dest_o  = cur_i;
    case (kind_i)
      REQ_BX: begin
        legal_o = from_branchable;
        dest_o  = tgt_lsb_i ? ISA_COMPACT : ISA_FIXED32;
      end
      REQ_BXJ: begin
        legal_o = from_branchable;
        dest_o  = ISA_BYTECODE;
      end
      REQ_ENTER: begin
        legal_o = (cur_i == ISA_COMPACT);
        dest_o  = ISA_EXTCOMPACT;
      end
      REQ_LEAVE: begin
        legal_o = (cur_i == ISA_EXTCOMPACT);
        dest_o  = ISA_COMPACT;
      end
      default: begin
        legal_o = 1'b0;
        dest_o  = cur_i;
      end
    endcase
  end

endmodule

// File: rtl/isa_align_chk.sv
`timescale 1ns/1ps
module isa_align_chk
  import isa_state_pkg::*;
(
  input  isa_state_e state_i,
  input  logic [1:0] addr_lsb_i,
  output logic       misaligned_o
);

  always_comb begin
    case (state_i)
      ISA_FIXED32:                 misaligned_o = |addr_lsb_i;
      ISA_COMPACT, ISA_EXTCOMPACT: misaligned_o = addr_lsb_i[0];
      default:                     misaligned_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/isa_state_ctrl.sv
`timescale 1ns/1ps
module isa_state_ctrl
  import isa_state_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SR_W       = 32,
  parameter int J_POS      = 24,
  parameter int T_POS      = 5,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_bx,
  input  logic              req_bxj,
  input  logic              req_enter,
  input  logic              req_leave,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              fetch_valid,
  input  logic [1:0]        fetch_addr_lsb,
  input  logic              sr_wr_en,
  input  logic [1:0]        sr_wr_jt,
  output logic              j_flag,
  output logic              t_flag,
  output logic [SR_W-1:0]   sr_image,
  output logic              illegal_transition,
  output logic              align_fault,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr
);

  localparam int JW = $clog2(SR_W);
  localparam logic [JW-1:0] J_IDX = JW'(J_POS);
  localparam logic [JW-1:0] T_IDX = JW'(T_POS);

  logic       rst_core_n;
  isa_req_t   req_vec;
  req_kind_e  req_kind;
  isa_state_e state_q, state_d, dest_state;
  logic       legal;
  logic       branch_req;
  logic       fetch_bad_raw, fetch_bad, tgt_bad_raw, tgt_bad;
  logic       illegal_d, align_d, redir_v_d;
  logic [ADDR_W-1:0] tgt_eff;

  isa_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_core_n)
  );

  assign req_vec = '{bx: req_bx, bxj: req_bxj, enter: req_enter, leave: req_leave};

  isa_req_decode u_decode (
    .req_i  (req_vec),
    .kind_o (req_kind)
  );

  isa_transition_rules u_rules (
    .cur_i     (state_q),
    .kind_i    (req_kind),
    .tgt_lsb_i (br_target[0]),
    .legal_o   (legal),
    .dest_o    (dest_state)
  );

  assign branch_req = (req_kind == REQ_BX) || (req_kind == REQ_BXJ);
  assign tgt_eff    = (req_kind == REQ_BX) ? {br_target[ADDR_W-1:1], 1'b0} : br_target;

  isa_align_chk u_fetch_align (
    .state_i      (state_q),
    .addr_lsb_i   (fetch_addr_lsb),
    .misaligned_o (fetch_bad_raw)
  );

  isa_align_chk u_tgt_align (
    .state_i      (dest_state),
    .addr_lsb_i   (tgt_eff[1:0]),
    .misaligned_o (tgt_bad_raw)
  );

  assign fetch_bad = fetch_valid & fetch_bad_raw;
  assign tgt_bad   = branch_req & tgt_bad_raw;

  // Next-state process
  always_comb begin
    state_d   = state_q;
    illegal_d = 1'b0;
    align_d   = fetch_bad;
    redir_v_d = 1'b0;
    if (sr_wr_en) begin
      state_d = isa_state_e'(sr_wr_jt);
    end else if (req_kind != REQ_NONE) begin
      if (!legal) begin
        illegal_d = 1'b1;
      end else if (fetch_bad || tgt_bad) begin
        align_d = 1'b1;
      end else begin
        state_d   = dest_state;
        redir_v_d = branch_req;
      end
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q            <= ISA_FIXED32;
      illegal_transition <= 1'b0;
      align_fault        <= 1'b0;
      redirect_valid     <= 1'b0;
      redirect_addr      <= '0;
    end else begin
      state_q            <= state_d;
      illegal_transition <= illegal_d;
      align_fault        <= align_d;
      redirect_valid     <= redir_v_d;
      if (redir_v_d) begin
        redirect_addr <= tgt_eff;
      end
    end
  end

  assign j_flag = state_q[1];
  assign t_flag = state_q[0];

  always_comb begin
    sr_image        = '0;
    sr_image[J_IDX] = state_q[1];
    sr_image[T_IDX] = state_q[0];
  end

endmodule

// File: rtl/isa_state_ctrl_chk.sv
`timescale 1ns/1ps
module isa_state_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] br_target,
  input logic              sr_wr_en,
  input logic [1:0]        sr_wr_jt,
  input logic              j_flag,
  input logic              t_flag,
  input logic              illegal_transition,
  input logic              align_fault,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_addr
);

  logic [1:0] jt;
  assign jt = {j_flag, t_flag};

  function automatic logic edge_ok(input logic [1:0] a, input logic [1:0] b);
    return (a == 2'b00 && b == 2'b01) || (a == 2'b01 && b == 2'b00) ||
           (a == 2'b01 && b == 2'b11) || (a == 2'b11 && b == 2'b01) ||
           (a == 2'b00 && b == 2'b10) || (a == 2'b01 && b == 2'b10);
  endfunction

  a_r6_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_transition |-> (jt == $past(jt)));

  a_r6_illegal_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_transition |-> !redirect_valid);

  a_r7_align_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (align_fault && !$past(sr_wr_en)) |-> (jt == $past(jt) && !redirect_valid));

  a_r4_legal_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (jt != $past(jt) && !$past(sr_wr_en)) |-> edge_ok($past(jt), jt));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sr_wr_en) |-> (jt == $past(sr_wr_jt) && !illegal_transition && !redirect_valid));

  a_r3_redirect_even: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && jt != 2'b10) |-> !redirect_addr[0]);

  a_r5_bytecode_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == 2'b10 && $past(jt) != 2'b10 && !$past(sr_wr_en)) |->
      (redirect_valid && redirect_addr == $past(br_target)));

  a_r9_redirect_means_branch: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !align_fault);

endmodule

bind isa_state_ctrl isa_state_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk                (clk),
  .rst_n              (rst_core_n),
  .br_target          (br_target),
  .sr_wr_en           (sr_wr_en),
  .sr_wr_jt           (sr_wr_jt),
  .j_flag             (j_flag),
  .t_flag             (t_flag),
  .illegal_transition (illegal_transition),
  .align_fault        (align_fault),
  .redirect_valid     (redirect_valid),
  .redirect_addr      (redirect_addr)
);

// File: tb/isa_state_ctrl_tb.sv
`timescale 1ns/1ps
module isa_state_ctrl_tb;

  localparam int AW = 32;
  localparam int SW = 32;
  localparam int JP = 24;
  localparam int TP = 5;

  logic          clk;
  logic          rst_n;
  logic          req_bx, req_bxj, req_enter, req_leave;
  logic [AW-1:0] br_target;
  logic          fetch_valid;
  logic [1:0]    fetch_addr_lsb;
  logic          sr_wr_en;
  logic [1:0]    sr_wr_jt;
  logic          j_flag, t_flag;
  logic [SW-1:0] sr_image;
  logic          illegal_transition, align_fault, redirect_valid;
  logic [AW-1:0] redirect_addr;

  int tests;
  int fails;

  typedef struct {
    logic [1:0]    jt;
    logic          ill;
    logic          al;
    logic          rv;
    logic [AW-1:0] ra;
    string         tag;
  } exp_t;

  exp_t       sb[$];
  logic [1:0] mstate;

  isa_state_ctrl #(.ADDR_W(AW), .SR_W(SW), .J_POS(JP), .T_POS(TP)) u_dut (
    .clk                (clk),
    .rst_n              (rst_n),
    .req_bx             (req_bx),
    .req_bxj            (req_bxj),
    .req_enter          (req_enter),
    .req_leave          (req_leave),
    .br_target          (br_target),
    .fetch_valid        (fetch_valid),
    .fetch_addr_lsb     (fetch_addr_lsb),
    .sr_wr_en           (sr_wr_en),
    .sr_wr_jt           (sr_wr_jt),
    .j_flag             (j_flag),
    .t_flag             (t_flag),
    .sr_image           (sr_image),
    .illegal_transition (illegal_transition),
    .align_fault        (align_fault),
    .redirect_valid     (redirect_valid),
    .redirect_addr      (redirect_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [SW-1:0] image_of(input logic [1:0] jt);
    logic [SW-1:0] img;
    img     = '0;
    img[JP] = jt[1];
    img[TP] = jt[0];
    return img;
  endfunction

  // Driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic bx, input logic bxj, input logic en, input logic lv,
                      input logic [AW-1:0] tgt, input logic fv, input logic [1:0] fa,
                      input logic we, input logic [1:0] wjt, input string tag);
    exp_t          e;
    int            n;
    logic          fbad, legal, tbad;
    logic [1:0]    dest, nxt;
    logic [AW-1:0] ta;
    @(negedge clk);
    req_bx = bx; req_bxj = bxj; req_enter = en; req_leave = lv;
    br_target = tgt; fetch_valid = fv; fetch_addr_lsb = fa;
    sr_wr_en = we; sr_wr_jt = wjt;
    n    = int'(bx) + int'(bxj) + int'(en) + int'(lv);
    fbad = fv && ((mstate == 2'b00 && fa != 2'b00) ||
                  ((mstate == 2'b01 || mstate == 2'b11) && fa[0]));
    e.tag = tag; e.ill = 1'b0; e.rv = 1'b0; e.ra = '0; e.al = fbad;
    nxt = mstate; legal = 1'b0; tbad = 1'b0; dest = mstate; ta = tgt;
    if (we) begin
      nxt = wjt;
    end else if (n > 1) begin
      e.ill = 1'b1;
    end else if (n == 1) begin
      if (bx) begin
        legal = (mstate == 2'b00 || mstate == 2'b01);
        dest  = tgt[0] ? 2'b01 : 2'b00;
        ta    = {tgt[AW-1:1], 1'b0};
        tbad  = (dest == 2'b00) && ta[1];
      end else if (bxj) begin
        legal = (mstate == 2'b00 || mstate == 2'b01);
        dest  = 2'b10;
      end else if (en) begin
        legal = (mstate == 2'b01);
        dest  = 2'b11;
      end else begin
        legal = (mstate == 2'b11);
        dest  = 2'b01;
      end
      if (!legal) e.ill = 1'b1;
      else if (fbad || tbad) e.al = 1'b1;
      else begin
        nxt  = dest;
        e.rv = bx | bxj;
        e.ra = ta;
      end
    end
    mstate = nxt;
    e.jt   = nxt;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 2'b00, 1'b0, 2'b00, tag);
  endtask

  // Monitor: pops one expected item per clock and compares
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      tests++;
      if ({j_flag, t_flag} != e.jt || illegal_transition != e.ill ||
          align_fault != e.al || redirect_valid != e.rv ||
          (e.rv && redirect_addr != e.ra) || sr_image != image_of(e.jt)) begin
        fails++;
        $display("FAIL %s: got jt=%b ill=%b al=%b rv=%b ra=%h img=%h, expected jt=%b ill=%b al=%b rv=%b ra=%h img=%h",
                 e.tag, {j_flag, t_flag}, illegal_transition, align_fault, redirect_valid,
                 redirect_addr, sr_image, e.jt, e.ill, e.al, e.rv, e.ra, image_of(e.jt));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; mstate = 2'b00;
    rst_n = 1'b0;
    req_bx = 1'b0; req_bxj = 1'b0; req_enter = 1'b0; req_leave = 1'b0;
    br_target = '0; fetch_valid = 1'b0; fetch_addr_lsb = 2'b00;
    sr_wr_en = 1'b0; sr_wr_jt = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    tests++;
    if ({j_flag, t_flag} != 2'b00 || illegal_transition || align_fault || redirect_valid ||
        sr_image != '0) begin
      fails++;
      $display("FAIL R1: got jt=%b ill=%b al=%b rv=%b img=%h, expected jt=00 ill=0 al=0 rv=0 img=0",
               {j_flag, t_flag}, illegal_transition, align_fault, redirect_valid, sr_image);
    end

    step(0,0,0,0, 32'h0, 1, 2'b00, 0, 2'b00, "R2 fixed aligned fetch");
    step(0,0,0,0, 32'h0, 1, 2'b10, 0, 2'b00, "R2 fixed halfword fetch faults");
    step(0,0,0,0, 32'h0, 0, 2'b11, 0, 2'b00, "R2 invalid fetch ignored");
    step(1,0,0,0, 32'h0000_0201, 0, 2'b00, 0, 2'b00, "R3 bx to compact");
    idle("R9 pulse ends");
    step(0,0,0,0, 32'h0, 1, 2'b10, 0, 2'b00, "R2 compact halfword ok");
    step(0,0,0,0, 32'h0, 1, 2'b11, 0, 2'b00, "R2 compact odd faults");
    step(0,0,1,0, 32'h0000_0003, 0, 2'b00, 0, 2'b00, "R4 enter extended");
    step(0,0,0,0, 32'h0, 1, 2'b01, 0, 2'b00, "R2 extended odd faults");
    step(1,0,0,0, 32'h0000_0101, 0, 2'b00, 0, 2'b00, "R6 bx in extended");
    step(0,0,1,0, 32'h0, 0, 2'b00, 0, 2'b00, "R6 enter in extended");
    step(0,1,0,0, 32'h0, 0, 2'b00, 0, 2'b00, "R6 bxj in extended");
    idle("R9 illegal pulse ends");
    step(0,0,0,1, 32'h0, 0, 2'b00, 0, 2'b00, "R4 leave extended");
    step(1,0,0,0, 32'h0000_0300, 0, 2'b00, 0, 2'b00, "R3 bx to fixed");
    step(0,0,1,0, 32'h0, 0, 2'b00, 0, 2'b00, "R6 enter in fixed");
    step(0,0,0,1, 32'h0, 0, 2'b00, 0, 2'b00, "R6 leave in fixed");
    step(1,0,0,0, 32'h0000_0302, 0, 2'b00, 0, 2'b00, "R7 bx target misaligned");
    step(1,0,0,0, 32'h0000_0501, 1, 2'b01, 0, 2'b00, "R7 bx with fetch fault");
    step(1,0,0,0, 32'h0000_0503, 0, 2'b00, 0, 2'b00, "R3 bx odd target to compact");
    step(1,0,1,0, 32'h0000_0601, 0, 2'b00, 0, 2'b00, "R6 two pulses");
    step(0,1,0,0, 32'h0000_0403, 0, 2'b00, 0, 2'b00, "R5 bxj from compact");
    step(0,0,0,0, 32'h0, 1, 2'b11, 0, 2'b00, "R2 bytecode any alignment");
    step(1,0,0,0, 32'h0000_0001, 0, 2'b00, 0, 2'b00, "R6 bx in bytecode");
    step(0,1,0,0, 32'h0000_0007, 0, 2'b00, 0, 2'b00, "R6 bxj in bytecode");
    step(0,0,0,0, 32'h0, 0, 2'b00, 1, 2'b00, "R8 write fixed");
    step(0,1,0,0, 32'h0000_0777, 0, 2'b00, 0, 2'b00, "R5 bxj from fixed");
    step(1,0,0,0, 32'h0000_0001, 0, 2'b00, 1, 2'b11, "R8 write beats bx");
    step(0,0,0,1, 32'h0, 0, 2'b00, 1, 2'b01, "R8 write beats leave");
    step(0,0,0,0, 32'h0, 1, 2'b01, 1, 2'b00, "R8 write with fetch fault");
    step(0,0,0,0, 32'h0, 0, 2'b00, 1, 2'b11, "R10 image extended");
    step(0,0,0,0, 32'h0, 0, 2'b00, 1, 2'b10, "R10 image bytecode");
    idle("R9 final idle");
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule